// File: doc/BRIEF.md
# Memory-Mapped 64-Source Interrupt Controller

This block gathers 64 interrupt lines that run on the bus clock and turns them into two request outputs, a normal request and a fast request. Each source can be sensed as a level or as an edge. Edge sources are held in a per-source latch until software clears that bit. A software trigger can also force a source pending. A per-source enable masks the source, and a per-source route bit steers it to the normal or the fast output.

Software reaches the controller through a plain 32-bit register port where each read or write takes one cycle. Every logical register is 64 bits wide and is split into two words. The low word covers sources 0 to 31 and sits at the register's base offset. The high word covers sources 32 to 63 and sits at the base offset plus 4. Enables and software triggers each have a write-one-to-set offset and a separate write-one-to-clear offset, so software never needs a read-modify-write to change them.

Top module: `intc_top`

## Requirements
- R1: After reset, irq_o and fiq_o are 0, and the enable, route, trigger and both-edges registers read 0. The sense and polarity registers read all ones, and every edge latch is clear.
- R2: Writing 1 bits to 0x20 sets those enables, and writing 1 bits to 0x28 clears them. Zero bits leave an enable unchanged. 0x20 reads back the enables.
- R3: Writing 1 bits to 0x30 sets the software trigger of those sources, and writing 1 bits to 0x38 clears it. 0x30 reads back the triggers, and a trigger bit is ORed into the raw status read at 0x10.
- R4: A source whose sense bit (0x40) is 1 is level-sensitive. Its raw status bit shows the input level one clock after the input is applied.
- R5: A source whose sense bit is 0 is edge-sensitive. When the both-edges bit (0x48) is 0, its latch sets on a rising input edge if the polarity bit (0x50) is 1, and on a falling edge if the polarity bit is 0. When the both-edges bit is 1, the latch sets on either edge. The latch is read at 0x60, drives the raw bit, and holds after the input returns until a 1 is written to its bit at 0x58.
- R6: Writing 1 bits to 0x58 does not change the raw status of a level-sensitive source.
- R7: Clearing a source's enable does not clear its edge latch. An edge captured while the source is masked appears in the status once the source is enabled again.
- R8: 0x00 reads raw AND enable AND NOT route, and 0x08 reads raw AND enable AND route. Route bits (0x18) reset to 0, which sends every source to the normal output.
- R9: irq_o is the registered OR of all 0x00/0x04 status bits, and fiq_o is the registered OR of all 0x08/0x0C status bits. Each output follows its status one clock later.
- R10: The write-only offsets 0x28, 0x38 and 0x58 (and their +4 words) read 0. Writes to the status offsets 0x00, 0x08 and 0x10 change nothing. Unmapped offsets, and addresses whose two low bits are not 00, read 0.
- R11: Address bit 2 selects the half: base+4 reads and writes sources 32 to 63, and base reads and writes sources 0 to 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus and sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Interrupt lines, synchronous to clk_i |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational while sel_i is 1 and we_i is 0 |
| irq_o | output | 1 | Registered normal request |
| fiq_o | output | 1 | Registered fast request |

## Verification
The bench builds the block with its default parameters: 64 sources and an 8-bit address. With these values both halves of the interleaved map and source 63 at the top of the high word are in reach, along with every offset up to 0x64 and unmapped addresses above it. A register-map vector table checks reset values, set/clear pairs, routing and ignored writes. Directed sequences on single lines then check level tracking, edge polarity, both-edge capture, latch retention while masked, and the one-cycle delay on the request outputs.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 13;

  // index = addr[6:3]; the offset order is software-visible
  typedef enum logic [3:0] {
    RG_IRQ      = 4'd0,
    RG_FIQ      = 4'd1,
    RG_RAW      = 4'd2,
    RG_ROUTE    = 4'd3,
    RG_ARM      = 4'd4,
    RG_DISARM   = 4'd5,
    RG_POKE     = 4'd6,
    RG_UNPOKE   = 4'd7,
    RG_LEVEL    = 4'd8,
    RG_BOTH     = 4'd9,
    RG_RISE     = 4'd10,
    RG_EDGE_CLR = 4'd11,
    RG_EDGE     = 4'd12
  } reg_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned SRC_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [SRC_W-1:0]  arm_o,
  output logic [SRC_W-1:0]  route_o,
  output logic [SRC_W-1:0]  poke_o,
  output logic [SRC_W-1:0]  level_o,
  output logic [SRC_W-1:0]  both_o,
  output logic [SRC_W-1:0]  rise_o,
  output logic [SRC_W-1:0]  edge_clr_o
);
  localparam int unsigned HALVES = SRC_W / WORD_W;

  logic [3:0] idx;
  logic       half;
  logic       wr_ok;
  logic [SRC_W-1:0] wvec, hmask;
  logic [NUM_REGS-1:0][SRC_W-1:0] wr_m;
  logic [SRC_W-1:0] arm_q, route_q, poke_q, level_q, both_q, rise_q;

  assign idx   = addr_i[6:3];
  assign half  = addr_i[2];
  assign wr_ok = sel_i && we_i && (addr_i[ADDR_W-1:7] == '0) && (addr_i[1:0] == 2'b00);

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign wvec [h*WORD_W +: WORD_W] = (int'(half) == h) ? wdata_i : '0;
    assign hmask[h*WORD_W +: WORD_W] = (int'(half) == h) ? '1 : '0;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_wr
    assign wr_m[r] = (wr_ok && idx == 4'(r)) ? wvec : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q   <= '0;
      poke_q  <= '0;
      route_q <= '0;
      level_q <= '1;
      both_q  <= '0;
      rise_q  <= '1;
    end else begin
      arm_q  <= (arm_q  | wr_m[RG_ARM])  & ~wr_m[RG_DISARM];
      poke_q <= (poke_q | wr_m[RG_POKE]) & ~wr_m[RG_UNPOKE];
      if (wr_ok && idx == RG_ROUTE) route_q <= (route_q & ~hmask) | wvec;
      if (wr_ok && idx == RG_LEVEL) level_q <= (level_q & ~hmask) | wvec;
      if (wr_ok && idx == RG_BOTH)  both_q  <= (both_q  & ~hmask) | wvec;
      if (wr_ok && idx == RG_RISE)  rise_q  <= (rise_q  & ~hmask) | wvec;
    end
  end

  assign arm_o      = arm_q;
  assign route_o    = route_q;
  assign poke_o     = poke_q;
  assign level_o    = level_q;
  assign both_o     = both_q;
  assign rise_o     = rise_q;
  assign edge_clr_o = wr_m[RG_EDGE_CLR];

  // R2
  arm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == RG_ARM) |=> ((arm_q & $past(wvec)) == $past(wvec)));
  // R2
  arm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == RG_DISARM) |=> ((arm_q & $past(wvec)) == '0));
  // R3
  poke_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && idx == RG_UNPOKE) |=> ((poke_q & $past(wvec)) == '0));
endmodule

// File: rtl/intc_edge.sv
module intc_edge #(
  parameter int unsigned SRC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  input  logic [SRC_W-1:0] level_i,
  input  logic [SRC_W-1:0] both_i,
  input  logic [SRC_W-1:0] rise_i,
  input  logic [SRC_W-1:0] clr_i,
  output logic [SRC_W-1:0] src_q_o,
  output logic [SRC_W-1:0] latch_o
);
  logic [SRC_W-1:0] src_q, latch_q;

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    logic up, dn, hit;
    assign up  = src_i[i] & ~src_q[i];
    assign dn  = ~src_i[i] & src_q[i];
    assign hit = both_i[i] ? (up | dn) : (rise_i[i] ? up : dn);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[i]   <= 1'b0;
        latch_q[i] <= 1'b0;
      end else begin
        src_q[i] <= src_i[i];
        // a new edge wins over a same-cycle clear
        if (level_i[i])    latch_q[i] <= 1'b0;
        else if (hit)      latch_q[i] <= 1'b1;
        else if (clr_i[i]) latch_q[i] <= 1'b0;
      end
    end
  end

  assign src_q_o = src_q;
  assign latch_o = latch_q;

  // R7
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(latch_q & ~clr_i & ~level_i)) == $past(latch_q & ~clr_i & ~level_i)));
  // R6
  level_no_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(level_i)) == '0));
endmodule

// File: rtl/intc_status.sv
module intc_status #(
  parameter int unsigned SRC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_q_i,
  input  logic [SRC_W-1:0] latch_i,
  input  logic [SRC_W-1:0] level_i,
  input  logic [SRC_W-1:0] poke_i,
  input  logic [SRC_W-1:0] arm_i,
  input  logic [SRC_W-1:0] route_i,
  output logic [SRC_W-1:0] raw_o,
  output logic [SRC_W-1:0] irq_stat_o,
  output logic [SRC_W-1:0] fiq_stat_o,
  output logic             irq_o,
  output logic             fiq_o
);
  logic irq_q, fiq_q;

  assign raw_o      = ((level_i & src_q_i) | (~level_i & latch_i)) | poke_i;
  assign irq_stat_o = raw_o & arm_i & ~route_i;
  assign fiq_stat_o = raw_o & arm_i & route_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |irq_stat_o;
      fiq_q <= |fiq_stat_o;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|irq_stat_o)));
  // R9
  fiq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fiq_o == $past(|fiq_stat_o)));
  // R8
  split_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_stat_o & fiq_stat_o) == '0);
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned SRC_W  = 64,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  src_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [SRC_W-1:0] arm, route, poke, level, both, rise, edge_clr;
  logic [SRC_W-1:0] src_q, latch, raw, irq_stat, fiq_stat;

  intc_regs #(.SRC_W(SRC_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .sel_i, .we_i, .addr_i, .wdata_i,
    .arm_o(arm), .route_o(route), .poke_o(poke), .level_o(level),
    .both_o(both), .rise_o(rise), .edge_clr_o(edge_clr)
  );

  intc_edge #(.SRC_W(SRC_W)) u_edge (
    .clk_i, .rst_ni, .src_i, .level_i(level), .both_i(both),
    .rise_i(rise), .clr_i(edge_clr), .src_q_o(src_q), .latch_o(latch)
  );

  intc_status #(.SRC_W(SRC_W)) u_status (
    .clk_i, .rst_ni, .src_q_i(src_q), .latch_i(latch), .level_i(level),
    .poke_i(poke), .arm_i(arm), .route_i(route), .raw_o(raw),
    .irq_stat_o(irq_stat), .fiq_stat_o(fiq_stat), .irq_o, .fiq_o
  );

  logic [3:0] idx;
  logic       half, rd_ok;
  assign idx   = addr_i[6:3];
  assign half  = addr_i[2];
  assign rd_ok = sel_i && !we_i && (addr_i[ADDR_W-1:7] == '0) && (addr_i[1:0] == 2'b00);

  function automatic logic [WORD_W-1:0] pick(input logic [SRC_W-1:0] v, input logic h);
    return v[int'(h)*WORD_W +: WORD_W];
  endfunction

  always_comb begin
    rdata_o = '0;
    if (rd_ok) begin
      case (idx)
        RG_IRQ:   rdata_o = pick(irq_stat, half);
        RG_FIQ:   rdata_o = pick(fiq_stat, half);
        RG_RAW:   rdata_o = pick(raw, half);
        RG_ROUTE: rdata_o = pick(route, half);
        RG_ARM:   rdata_o = pick(arm, half);
        RG_POKE:  rdata_o = pick(poke, half);
        RG_LEVEL: rdata_o = pick(level, half);
        RG_BOTH:  rdata_o = pick(both, half);
        RG_RISE:  rdata_o = pick(rise, half);
        RG_EDGE:  rdata_o = pick(latch, half);
        default:  rdata_o = '0;
      endcase
    end
  end

  // R10
  clr_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && (idx == RG_DISARM || idx == RG_UNPOKE || idx == RG_EDGE_CLR))
    |-> (rdata_o == '0));
endmodule

// File: tb/intc_top_bench.sv
module intc_top_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h20, 32'h0000_0000, 8'd1},  // R1
    '{1'b0, 8'h40, 32'hFFFF_FFFF, 8'd1},  // R1
    '{1'b0, 8'h50, 32'hFFFF_FFFF, 8'd1},  // R1
    '{1'b0, 8'h48, 32'h0000_0000, 8'd1},  // R1
    '{1'b0, 8'h18, 32'h0000_0000, 8'd8},  // R8
    '{1'b1, 8'h20, 32'h0000_00F0, 8'd2},  // R2
    '{1'b0, 8'h20, 32'h0000_00F0, 8'd2},
    '{1'b1, 8'h20, 32'h0000_0003, 8'd2},
    '{1'b0, 8'h20, 32'h0000_00F3, 8'd2},
    '{1'b1, 8'h28, 32'h0000_0030, 8'd2},
    '{1'b0, 8'h20, 32'h0000_00C3, 8'd2},
    '{1'b0, 8'h28, 32'h0000_0000, 8'd10}, // R10
    '{1'b1, 8'h24, 32'h8000_0001, 8'd11}, // R11
    '{1'b0, 8'h24, 32'h8000_0001, 8'd11},
    '{1'b0, 8'h20, 32'h0000_00C3, 8'd11},
    '{1'b1, 8'h30, 32'h0000_0100, 8'd3},  // R3
    '{1'b0, 8'h10, 32'h0000_0100, 8'd3},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd8},
    '{1'b1, 8'h20, 32'h0000_0100, 8'd8},
    '{1'b0, 8'h00, 32'h0000_0100, 8'd8},
    '{1'b1, 8'h18, 32'h0000_0100, 8'd8},
    '{1'b0, 8'h00, 32'h0000_0000, 8'd8},
    '{1'b0, 8'h08, 32'h0000_0100, 8'd8},
    '{1'b0, 8'h18, 32'h0000_0100, 8'd8},
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 8'd10},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'd10},
    '{1'b0, 8'h08, 32'h0000_0100, 8'd10},
    '{1'b0, 8'h10, 32'h0000_0100, 8'd10},
    '{1'b1, 8'h38, 32'h0000_0100, 8'd3},
    '{1'b0, 8'h10, 32'h0000_0000, 8'd3},
    '{1'b0, 8'h08, 32'h0000_0000, 8'd3},
    '{1'b0, 8'h70, 32'h0000_0000, 8'd10},
    '{1'b0, 8'h38, 32'h0000_0000, 8'd10},
    '{1'b0, 8'h58, 32'h0000_0000, 8'd10},
    '{1'b0, 8'h30, 32'h0000_0000, 8'd3},
    '{1'b0, 8'h64, 32'h0000_0000, 8'd5}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_top u_intc_top (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rdw(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(1, {31'b0, irq}, 32'd0);  // R1 during reset
    chk(1, {31'b0, fiq}, 32'd0);
    step();
    rst_n = 1'b1;
    step();
    chk(1, {31'b0, irq}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else begin
        rdw(VECS[i].addr, rd);
        chk(int'(VECS[i].req), rd, VECS[i].data);
      end
    end
    // state: arm low 0x1C3, arm high 0x80000001, route 0x100

    // R4 level source 6, R9 one-cycle output delay
    src[6] = 1'b1; step();
    rdw(8'h10, rd); chk(4, rd, 32'h40);
    chk(9, {31'b0, irq}, 32'd0);
    step();
    chk(9, {31'b0, irq}, 32'd1);
    rdw(8'h00, rd); chk(8, rd, 32'h40);
    // R6 edge clear on a level source
    wr(8'h58, 32'h40);
    rdw(8'h10, rd); chk(6, rd, 32'h40);
    src[6] = 1'b0; step();
    rdw(8'h10, rd); chk(4, rd, 32'h0);
    step();
    chk(9, {31'b0, irq}, 32'd0);

    // R5 rising edge on source 7
    wr(8'h40, 32'hFFFF_FF7F);
    src[7] = 1'b1; step();
    src[7] = 1'b0; step();
    rdw(8'h60, rd); chk(5, rd, 32'h80);
    rdw(8'h10, rd); chk(5, rd, 32'h80);
    chk(9, {31'b0, irq}, 32'd1);
    wr(8'h58, 32'h80);
    rdw(8'h60, rd); chk(5, rd, 32'h0);
    // R5 falling polarity
    wr(8'h50, 32'hFFFF_FF7F);
    src[7] = 1'b1; step();
    rdw(8'h60, rd); chk(5, rd, 32'h0);
    src[7] = 1'b0; step();
    rdw(8'h60, rd); chk(5, rd, 32'h80);
    wr(8'h58, 32'h80);
    // R5 both edges
    wr(8'h48, 32'h80);
    src[7] = 1'b1; step();
    rdw(8'h60, rd); chk(5, rd, 32'h80);
    wr(8'h58, 32'h80);
    rdw(8'h60, rd); chk(5, rd, 32'h0);
    src[7] = 1'b0; step();
    rdw(8'h60, rd); chk(5, rd, 32'h80);
    wr(8'h58, 32'h80);
    wr(8'h48, 32'h0);
    wr(8'h50, 32'hFFFF_FFFF);

    // R7 edge while masked survives the mask
    wr(8'h28, 32'h80);
    src[7] = 1'b1; step();
    src[7] = 1'b0; step();
    rdw(8'h00, rd); chk(7, rd, 32'h0);
    rdw(8'h60, rd); chk(7, rd, 32'h80);
    wr(8'h20, 32'h80);
    rdw(8'h00, rd); chk(7, rd, 32'h80);
    step();
    chk(7, {31'b0, irq}, 32'd1);
    wr(8'h58, 32'h80);
    step();
    chk(9, {31'b0, irq}, 32'd0);

    // R8 fast route through a software trigger on source 8
    wr(8'h30, 32'h100);
    step();
    chk(8, {31'b0, fiq}, 32'd1);
    chk(8, {31'b0, irq}, 32'd0);
    rdw(8'h08, rd); chk(8, rd, 32'h100);
    wr(8'h38, 32'h100);
    step();
    chk(9, {31'b0, fiq}, 32'd0);

    // R11 high half, source 63
    src[63] = 1'b1; step();
    rdw(8'h14, rd); chk(11, rd, 32'h8000_0000);
    rdw(8'h04, rd); chk(11, rd, 32'h8000_0000);
    rdw(8'h10, rd); chk(11, rd, 32'h0);
    rdw(8'h12, rd); chk(10, rd, 32'h0);
    step();
    chk(11, {31'b0, irq}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule